// File: doc/BRIEF.md
# Two-wire serial memory slave engine

This block is the slave side of a two-wire serial memory. It samples the clock line and the data line with a fast system clock. It recognises start and stop conditions and takes in bytes bit by bit. It decides whether the first byte of a transfer addresses this device. It then loads a two-byte word address, passes write bytes on to a page buffer, or shifts memory data out to the master. It acknowledges every byte it accepts. It pulls the data line low through a single open-drain enable and never drives it high.

The word-address counter is kept inside the block and survives from one transfer to the next, so a read with no address phase continues where the previous access stopped. Reads step through the whole array and wrap from the top address to zero. Writes step only within the current 32-byte page. The memory array is outside this block. It is reached through a combinational read port, and each accepted write byte appears as a one-cycle pulse carrying its address and data.

Top module: `eeprom_serial_slave`

## Requirements
- R1: Data falling while the clock is high is a start, and the block then begins to take in a device byte. Data rising while the clock is high is a stop, and the block then goes idle with the data line released. Out of reset the data line is released and no write pulse is present.
- R2: The device byte is accepted only when its bits 7:4 are 1010 and its bits 3:1 equal `strap[2:1:0]`. Bit 0 is the direction: 1 for read, 0 for write. On a mismatch the block does not acknowledge, and it ignores all later bytes until the next start.
- R3: Each accepted byte, whether a device, address or write-data byte, is acknowledged by pulling the data line low for the whole ninth clock.
- R4: A write header is followed by a high address byte and a low address byte. The low ADDR_W bits of the pair are loaded into the word counter, and the upper bits are ignored.
- R5: Each write-data byte after the address bytes produces exactly one `wr_valid` pulse, carrying the byte on `wr_data` and the current word address on `wr_addr`.
- R6: After a write byte, only the low 5 address bits advance, so bit 4:0 wraps from 31 to 0 and the upper bits are kept.
- R7: A read with no address phase starts at the word counter, which holds the last accessed address plus one and persists between transfers.
- R8: A write header with address bytes, then a repeated start and a read header, reads from the address just loaded.
- R9: During a read, each acknowledge from the master makes the block send the next byte. The address advances over the whole array and wraps from 2^ADDR_W-1 to 0.
- R10: When the master does not acknowledge a read byte, the block releases the data line and stays silent until the next start.
- R11: The data-line enable changes only while the sampled clock is low.
- R12: A start that arrives in the middle of a byte drops that byte and restarts device-byte reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level as seen on the bus |
| strap | input | 3 | Device select strap bits |
| sda_drive_low | output | 1 | Open-drain enable: 1 pulls the data line low |
| mem_rd_addr | output | ADDR_W | Word counter, used as the memory read address |
| mem_rd_data | input | 8 | Memory byte at mem_rd_addr, combinational |
| wr_valid | output | 1 | One-cycle pulse per accepted write byte |
| wr_addr | output | ADDR_W | Target address of the write byte |
| wr_data | output | 8 | Write byte |

## Verification
Line events reach the engine two system clocks after the pins change, and the engine's registers act one clock later. The data-line enable therefore follows a falling serial clock by about three clocks, and `wr_valid` follows the eighth rising edge by about three clocks. The bench holds each serial clock phase for eight system clocks. It reads acknowledge bits and data bits in the middle of the high phase, well after the enable has settled. It takes write pulses on falling system-clock edges and compares them in order against addresses it computes itself. The check that the enable moves only while the clock is low runs on every cycle of the whole run.

// File: rtl/ses_pkg.sv
package ses_pkg;
  localparam logic [3:0] DEV_PREFIX = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_AHI, ST_AHI_ACK,
    ST_ALO, ST_ALO_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } ses_state_t;

  // device byte decode: fixed prefix, strap match; bit 0 is direction
  function automatic logic dev_hit(input logic [7:0] b, input logic [2:0] strap);
    return (b[7:4] == DEV_PREFIX) && (b[3:1] == strap);
  endfunction
endpackage

// File: rtl/ses_line_sync.sv
module ses_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_in};
      sda_q <= {sda_q[STAGES-2:0], sda_in};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_lvl   = scl_q[STAGES-1];
  assign sda_lvl   = sda_q[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_p;
  assign scl_fall  = ~scl_lvl & scl_p;
  assign start_evt = scl_lvl & scl_p & sda_p & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_p & ~sda_p & sda_lvl;
endmodule

// File: rtl/ses_word_ctr.sv
module ses_word_ctr #(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              rd_step,
  input  logic              wr_step,
  output logic [ADDR_W-1:0] addr
);
  // reads run over the whole array
  function automatic logic [ADDR_W-1:0] step_linear(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  // writes stay inside the page
  function automatic logic [ADDR_W-1:0] step_page(input logic [ADDR_W-1:0] a);
    logic [PAGE_W-1:0] lo;
    lo = a[PAGE_W-1:0] + PAGE_W'(1);
    return {a[ADDR_W-1:PAGE_W], lo};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (load)    addr <= load_val;
    else if (wr_step) addr <= step_page(addr);
    else if (rd_step) addr <= step_linear(addr);
  end
endmodule

// File: rtl/eeprom_serial_slave.sv
module eeprom_serial_slave
  import ses_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int PAGE_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [2:0]        strap,
  output logic              sda_drive_low,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  localparam int HI_W = ADDR_W - 8;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  ses_state_t state, ack_next;
  logic [2:0]      bitcnt;
  logic [7:0]      shreg, rx_byte;
  logic [HI_W-1:0] addr_hi;
  logic            rw_q, drive_q, got_ack;
  logic            byte_done, rd_load, ctr_load, ctr_wstep;
  logic [ADDR_W-1:0] ctr_addr;

  ses_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
  );

  assign rx_byte   = {shreg[6:0], sda_lvl};
  assign byte_done = scl_rise && (bitcnt == 3'd7);
  assign ctr_load  = (state == ST_ALO) && byte_done;
  assign ctr_wstep = (state == ST_WR) && byte_done;
  assign rd_load   = scl_fall &&
                     (((state == ST_DEV_ACK) && drive_q && rw_q) ||
                      ((state == ST_RD_ACK) && got_ack));

  ses_word_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ctr_load),
    .load_val({addr_hi, rx_byte}), .rd_step(rd_load),
    .wr_step(ctr_wstep), .addr(ctr_addr)
  );

  always_comb begin
    case (state)
      ST_DEV_ACK: ack_next = rw_q ? ST_RD : ST_AHI;
      ST_AHI_ACK: ack_next = ST_ALO;
      default:    ack_next = ST_WR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      addr_hi  <= '0;
      rw_q     <= 1'b0;
      drive_q  <= 1'b0;
      got_ack  <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (start_evt) begin
        state   <= ST_DEV;
        bitcnt  <= '0;
        drive_q <= 1'b0;
      end else if (stop_evt) begin
        state   <= ST_IDLE;
        drive_q <= 1'b0;
      end else begin
        case (state)
          ST_DEV, ST_AHI, ST_ALO, ST_WR: begin
            if (scl_rise) begin
              shreg  <= rx_byte;
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) begin
                if (state == ST_DEV) begin
                  if (dev_hit(rx_byte, strap)) begin
                    rw_q  <= rx_byte[0];
                    state <= ST_DEV_ACK;
                  end else begin
                    state <= ST_IDLE;
                  end
                end else if (state == ST_AHI) begin
                  addr_hi <= rx_byte[HI_W-1:0];
                  state   <= ST_AHI_ACK;
                end else if (state == ST_ALO) begin
                  state <= ST_ALO_ACK;
                end else begin
                  wr_valid <= 1'b1;
                  wr_addr  <= ctr_addr;
                  wr_data  <= rx_byte;
                  state    <= ST_WR_ACK;
                end
              end
            end
          end
          ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WR_ACK: begin
            if (scl_fall) begin
              if (!drive_q) begin
                drive_q <= 1'b1;            // ninth clock begins
              end else begin
                drive_q <= 1'b0;
                bitcnt  <= '0;
                state   <= ack_next;
                if (rd_load) begin
                  shreg   <= {mem_rd_data[6:0], 1'b1};
                  drive_q <= ~mem_rd_data[7];
                end
              end
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (bitcnt == 3'd7) begin
                drive_q <= 1'b0;
                bitcnt  <= '0;
                state   <= ST_RD_ACK;
              end else begin
                drive_q <= ~shreg[7];
                shreg   <= {shreg[6:0], 1'b1};
                bitcnt  <= bitcnt + 3'd1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) got_ack <= ~sda_lvl;
            if (scl_fall) begin
              if (got_ack) begin
                shreg   <= {mem_rd_data[6:0], 1'b1};
                drive_q <= ~mem_rd_data[7];
                state   <= ST_RD;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_drive_low = drive_q;
  assign mem_rd_addr   = ctr_addr;
endmodule

// File: rtl/ses_checker.sv
module ses_checker
  import ses_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              scl_lvl,
  input ses_state_t        state,
  input logic [2:0]        bitcnt,
  input logic              sda_drive_low,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [ADDR_W-1:0] mem_rd_addr
);
  p_start_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == ST_DEV) && (bitcnt == 3'd0) && !sda_drive_low);

  p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (state == ST_IDLE) && !sda_drive_low);

  p_idle_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_drive_low);

  p_drive_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_drive_low != $past(sda_drive_low)) |-> !$past(scl_lvl));

  p_page_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (mem_rd_addr[ADDR_W-1:PAGE_W] == wr_addr[ADDR_W-1:PAGE_W]) &&
                 (mem_rd_addr[PAGE_W-1:0] == PAGE_W'(wr_addr[PAGE_W-1:0] + PAGE_W'(1))));

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
endmodule

bind eeprom_serial_slave ses_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
  .scl_lvl(scl_lvl), .state(state), .bitcnt(bitcnt),
  .sda_drive_low(sda_drive_low), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .mem_rd_addr(mem_rd_addr)
);

// File: tb/eeprom_serial_slave_test.sv
module eeprom_serial_slave_test;
  localparam int AW = 12;
  localparam int Q  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'd5;
  logic sda_drive_low, wr_valid;
  logic [AW-1:0] mem_rd_addr, wr_addr;
  logic [7:0] mem_rd_data, wr_data;
  logic sda_bus;

  int checks = 0, fails = 0, nwr = 0, r11_viol = 0;
  bit done = 0;
  logic [AW-1:0] cap_addr [0:63];
  logic [7:0]    cap_data [0:63];

  always #2.5 clk = ~clk;

  function automatic logic [7:0] romf(input logic [AW-1:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
  endfunction

  assign sda_bus     = sda_m & ~sda_drive_low;
  assign mem_rd_data = romf(mem_rd_addr);

  eeprom_serial_slave #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus), .strap(strap),
    .sda_drive_low(sda_drive_low), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data)
  );

  logic prev_drive = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid && nwr < 64) begin
        cap_addr[nwr] = wr_addr;
        cap_data[nwr] = wr_data;
      end
      if (wr_valid) nwr++;
      if (sda_drive_low != prev_drive && scl_m) r11_viol++;  // R11 monitor
    end
    prev_drive = sda_drive_low;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic bit_io(input logic b, output logic r);
    sda_m = b; wq(); scl_m = 1'b1; wq(); r = sda_bus; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(v[i], r);
    bit_io(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic mack);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, r);
      v[i] = r;
    end
    bit_io(~mack, r);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    finish_run();
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int base;
    repeat (4) @(negedge clk);
    chk(sda_drive_low == 1'b0, "R1 reset release", sda_drive_low, 0);
    chk(wr_valid == 1'b0, "R1 reset no write", wr_valid, 0);
    rst_n = 1'b1;
    wq();

    // page write at 0x31C with upper address bits set (ignored): six bytes
    bus_start();
    send_byte(8'hAA, ack); chk(ack, "R2 device ack", ack, 1);
    send_byte(8'hF3, ack); chk(ack, "R4 high addr ack", ack, 1);
    send_byte(8'h1C, ack); chk(ack, "R4 low addr ack", ack, 1);
    for (int k = 0; k < 6; k++) begin
      send_byte(8'h40 + 8'(k), ack);
      chk(ack, "R3 data ack", ack, 1);
    end
    bus_stop();
    chk(nwr == 6, "R5 write count", nwr, 6);
    for (int k = 0; k < 6; k++) begin
      chk(cap_addr[k] == (12'h300 | 12'((28 + k) % 32)), "R6 page wrap addr",
          cap_addr[k], 12'h300 | 12'((28 + k) % 32));
      chk(cap_data[k] == 8'h40 + 8'(k), "R5 write data", cap_data[k], 8'h40 + k);
    end

    // current-address reads continue from last write + 1
    bus_start();
    send_byte(8'hAB, ack); chk(ack, "R7 read header ack", ack, 1);
    recv_byte(d, 1'b0);
    chk(sda_drive_low == 1'b0, "R10 released after nack", sda_drive_low, 0);
    bus_stop();
    chk(d == romf(12'h302), "R7 current read", d, romf(12'h302));
    chk(sda_drive_low == 1'b0, "R10 released after stop", sda_drive_low, 0);
    bus_start();
    send_byte(8'hAB, ack);
    recv_byte(d, 1'b0);
    bus_stop();
    chk(d == romf(12'h303), "R7 counter persists", d, romf(12'h303));

    // random read at 0xFFE, sequential over the top of the array
    bus_start();
    send_byte(8'hAA, ack);
    send_byte(8'h0F, ack);
    send_byte(8'hFE, ack);
    bus_start();
    send_byte(8'hAB, ack); chk(ack, "R8 repeated start ack", ack, 1);
    recv_byte(d, 1'b1); chk(d == romf(12'hFFE), "R8 random read", d, romf(12'hFFE));
    recv_byte(d, 1'b1); chk(d == romf(12'hFFF), "R9 sequential", d, romf(12'hFFF));
    recv_byte(d, 1'b0); chk(d == romf(12'h000), "R9 array wrap", d, romf(12'h000));
    chk(sda_drive_low == 1'b0, "R10 nack release", sda_drive_low, 0);
    bus_stop();
    chk(nwr == 6, "R8 no write from dummy header", nwr, 6);

    // strap sweep: every strap against every device select
    for (int s = 0; s < 8; s++) begin
      for (int a = 0; a < 8; a++) begin
        strap = 3'(s);
        bus_start();
        send_byte({4'hA, 3'(a), 1'b0}, ack);
        chk(ack == (a == s), "R2 strap compare", ack, a == s);
        if (a != s) begin
          send_byte(8'h55, ack);
          chk(!ack, "R2 ignored after mismatch", ack, 0);
        end
        bus_stop();
      end
    end
    strap = 3'd5;
    bus_start();
    send_byte(8'hBA, ack); chk(!ack, "R2 wrong prefix", ack, 0);
    send_byte(8'h00, ack); chk(!ack, "R2 wrong prefix silent", ack, 0);
    bus_stop();
    chk(nwr == 6, "R2 no write on mismatch", nwr, 6);

    // start in the middle of a byte restarts device reception
    bus_start();
    begin
      logic r;
      for (int i = 0; i < 4; i++) bit_io(i[0] ? 1'b0 : 1'b1, r);
    end
    bus_start();
    send_byte(8'hAB, ack); chk(ack, "R12 restart ack", ack, 1);
    recv_byte(d, 1'b0);
    bus_stop();
    chk(d == romf(12'h001), "R12 restart read", d, romf(12'h001));

    // full page plus two: overwrite wraps to page start
    base = nwr;
    bus_start();
    send_byte(8'hAA, ack);
    send_byte(8'h07, ack);
    send_byte(8'hE0, ack);
    for (int k = 0; k < 34; k++) send_byte(8'(k * 3), ack);
    bus_stop();
    chk(nwr - base == 34, "R5 page burst count", nwr - base, 34);
    for (int k = 0; k < 34; k++) begin
      chk(cap_addr[base + k] == 12'h7E0 + 12'(k % 32), "R6 burst addr",
          cap_addr[base + k], 12'h7E0 + (k % 32));
      chk(cap_data[base + k] == 8'(k * 3), "R5 burst data", cap_data[base + k], k * 3);
    end
    bus_start();
    send_byte(8'hAB, ack);
    recv_byte(d, 1'b0);
    bus_stop();
    chk(d == romf(12'h7E2), "R6 counter after wrap", d, romf(12'h7E2));

    chk(r11_viol == 0, "R11 enable moves only with clock low", r11_viol, 0);
    finish_run();
  end
endmodule